// File: doc/BRIEF.md
# Rotary Encoder Event Status Register

This block is an AXI4-Lite slave that holds a single 32-bit status word for a hand-turned rotary knob. It receives single-cycle step pulses for each turning direction from an upstream decoder, plus the already debounced level of the knob's push switch. Each of these three events sets its own sticky flag. The processor polls the word and finds out what happened since its previous poll.

A read returns the flags and then clears the flags it returned, so software sees each event once. The read data is captured in the cycle the read address is accepted. When the read data handshake completes, only the bits reported in that capture are cleared. Any event that arrives from the capture cycle onward is therefore kept for the next read. Writes complete normally but change nothing.

Top module: `enc_status_axil`

## Requirements
- R1: The word at byte offset 0 carries the clockwise flag in bit 5, the counter-clockwise flag in bit 4 and the switch-press flag in bit 0; every other bit of any read reads as 0.
- R2: A one-cycle pulse on `cw_pulse` or `ccw_pulse` sets its flag, and the flag stays set until a read at offset 0 reports it.
- R3: Bit 0 is set only by a low-to-high change of `sw_level`. Holding the switch high or releasing it sets nothing, and a switch already high when reset ends is not a press.
- R4: A read at offset 0 returns the flags as they stood when the read address was accepted. When RVALID and RREADY are both high, exactly the flags that read returned are cleared, so an immediate second read returns 0.
- R5: An event whose pulse coincides with the read address acceptance, or with the read data handshake, is not lost: it appears in the following read.
- R6: A read whose word index (address bits above bit 1) is nonzero returns 0 and clears no flag.
- R7: ARREADY is high exactly when no read response is pending. RVALID stays high with unchanged RDATA until RREADY. RRESP is always 00 (OKAY).
- R8: Write address and write data are accepted in either order. One write response with BRESP 00 follows, held until BREADY, and the flags are unchanged.
- R9: After reset all flags are 0, RVALID and BVALID are low, and ARREADY, AWREADY and WREADY are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_pulse | input | 1 | One-cycle clockwise step event |
| ccw_pulse | input | 1 | One-cycle counter-clockwise step event |
| sw_level | input | 1 | Debounced push switch level |
| s_awaddr | input | AW | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data (ignored) |
| s_wstrb | input | 4 | Write strobes (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AW | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The bench targets the race between events and reads. It injects pulses in the exact cycle the address is accepted and in the cycle of the data handshake. A design that cleared the whole word, or cleared it before honouring a coincident set, would drop those steps and the next read would come back empty. It stalls RREADY for several cycles while new events arrive. A design that sampled the flags live would change RDATA under a valid response, and one that cleared unreported bits would lose those events. It also holds the switch high across reset and keeps it pressed across reads. A level-sensitive or wrongly reset edge detector would report phantom presses. Finally, it reads at a nonzero offset and writes all ones, expecting both to leave the flags untouched.

// File: rtl/enc_status_pkg.sv
package enc_status_pkg;
  localparam int DW      = 32;
  localparam int POS_CW  = 5;
  localparam int POS_CCW = 4;
  localparam int POS_SW  = 0;
  localparam logic [DW-1:0] USED_MASK =
    (DW'(1) << POS_CW) | (DW'(1) << POS_CCW) | (DW'(1) << POS_SW);
  localparam logic [1:0] RESP_OKAY = 2'b00;

  function automatic logic [DW-1:0] pack_events(input logic cw, input logic ccw,
                                                input logic sw_rise);
    logic [DW-1:0] v;
    v = '0;
    v[POS_CW]  = cw;
    v[POS_CCW] = ccw;
    v[POS_SW]  = sw_rise;
    return v;
  endfunction

  // set wins over clear so a coincident event survives
  function automatic logic [DW-1:0] next_flags(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] set_v,
                                               input logic [DW-1:0] clr_v);
    return ((cur & ~clr_v) | set_v) & USED_MASK;
  endfunction

  function automatic logic word_hit(input logic [DW-1:0] addr_bits);
    return (addr_bits >> 2) == '0;
  endfunction
endpackage

// File: rtl/sw_rise_detect.sv
module sw_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic prev_q;
  // prev resets high: a switch held through reset is not a press
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level;
  end
  assign rise = level & ~prev_q;
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags
  import enc_status_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  output logic [DW-1:0] flags
);
  logic [DW-1:0] nxt;
  assign nxt = next_flags(flags, set_vec, clr_vec);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (USED_MASK[i]) begin : g_used
      always_ff @(posedge clk) begin
        if (!rst_n) flags[i] <= 1'b0;
        else        flags[i] <= nxt[i];
      end
    end else begin : g_tie
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/axil_rd_chan.sv
module axil_rd_chan
  import enc_status_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] araddr,
  input  logic          arvalid,
  output logic          arready,
  output logic [DW-1:0] rdata,
  output logic [1:0]    rresp,
  output logic          rvalid,
  input  logic          rready,
  input  logic [DW-1:0] flags,
  output logic          ar_fire,
  output logic          hit_q,
  output logic [DW-1:0] clr_vec
);
  logic          rvalid_q;
  logic [DW-1:0] rdata_q;
  logic          hit_now;

  assign arready = ~rvalid_q;
  assign ar_fire = arvalid & arready;
  assign hit_now = word_hit(DW'(araddr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      hit_q    <= 1'b0;
    end else if (ar_fire) begin
      rvalid_q <= 1'b1;
      hit_q    <= hit_now;
      rdata_q  <= hit_now ? flags : '0;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end

  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = RESP_OKAY;
  assign clr_vec = (rvalid_q && rready && hit_q) ? rdata_q : '0;
endmodule

// File: rtl/axil_wr_chan.sv
module axil_wr_chan (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       awvalid,
  output logic       awready,
  input  logic       wvalid,
  output logic       wready,
  output logic [1:0] bresp,
  output logic       bvalid,
  input  logic       bready
);
  logic aw_got_q, w_got_q, bvalid_q;
  logic have_aw, have_w;

  assign awready = ~bvalid_q & ~aw_got_q;
  assign wready  = ~bvalid_q & ~w_got_q;
  assign have_aw = aw_got_q | (awvalid & awready);
  assign have_w  = w_got_q  | (wvalid & wready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_got_q <= 1'b0;
      w_got_q  <= 1'b0;
      bvalid_q <= 1'b0;
    end else if (have_aw && have_w) begin
      aw_got_q <= 1'b0;
      w_got_q  <= 1'b0;
      bvalid_q <= 1'b1;
    end else begin
      aw_got_q <= have_aw;
      w_got_q  <= have_w;
      if (bvalid_q && bready) bvalid_q <= 1'b0;
    end
  end

  assign bvalid = bvalid_q;
  assign bresp  = 2'b00;
endmodule

// File: rtl/enc_status_axil.sv
module enc_status_axil
  import enc_status_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_pulse,
  input  logic          ccw_pulse,
  input  logic          sw_level,
  input  logic [AW-1:0] s_awaddr,
  input  logic          s_awvalid,
  output logic          s_awready,
  input  logic [31:0]   s_wdata,
  input  logic [3:0]    s_wstrb,
  input  logic          s_wvalid,
  output logic          s_wready,
  output logic [1:0]    s_bresp,
  output logic          s_bvalid,
  input  logic          s_bready,
  input  logic [AW-1:0] s_araddr,
  input  logic          s_arvalid,
  output logic          s_arready,
  output logic [31:0]   s_rdata,
  output logic [1:0]    s_rresp,
  output logic          s_rvalid,
  input  logic          s_rready
);
  // named internal events, visible to the bound checker
  logic          sw_rise;
  logic          ar_fire;
  logic          rd_hit;
  logic [DW-1:0] ev_vec;
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] flag_vec;

  logic unused_wr;
  assign unused_wr = ^{s_awaddr, s_wdata, s_wstrb};

  sw_rise_detect u_rise (
    .clk(clk), .rst_n(rst_n), .level(sw_level), .rise(sw_rise)
  );

  assign ev_vec = pack_events(cw_pulse, ccw_pulse, sw_rise);

  sticky_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(ev_vec), .clr_vec(clr_vec), .flags(flag_vec)
  );

  axil_rd_chan #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .flags(flag_vec), .ar_fire(ar_fire), .hit_q(rd_hit), .clr_vec(clr_vec)
  );

  axil_wr_chan u_wr (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready),
    .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready)
  );
endmodule

// File: rtl/enc_status_chk.sv
module enc_status_chk
  import enc_status_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          cw_pulse,
  input logic          ccw_pulse,
  input logic          sw_level,
  input logic          s_arready,
  input logic [31:0]   s_rdata,
  input logic [1:0]    s_rresp,
  input logic          s_rvalid,
  input logic          s_rready,
  input logic [1:0]    s_bresp,
  input logic          s_bvalid,
  input logic          s_bready,
  input logic          rd_hit,
  input logic [DW-1:0] flag_vec
);
  // R1
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> (s_rdata & ~USED_MASK) == '0);
  // R2
  cw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_pulse |=> flag_vec[POS_CW]);
  // R2
  ccw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ccw_pulse |=> flag_vec[POS_CCW]);
  // R3
  sw_rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_level && !$past(sw_level)) |=> flag_vec[POS_SW]);
  // R3
  sw_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_vec[POS_SW] && !(sw_level && !$past(sw_level))) |=> !flag_vec[POS_SW]);
  // R4
  cw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && s_rready && rd_hit && s_rdata[POS_CW] && !cw_pulse) |=> !flag_vec[POS_CW]);
  // R6
  miss_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && s_rready && !rd_hit && flag_vec[POS_CCW]) |=> flag_vec[POS_CCW]);
  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
  // R7
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_arready);
  // R7
  rresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_rresp == RESP_OKAY);
  // R8
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> s_bvalid);
  // R8
  bresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> s_bresp == RESP_OKAY);
endmodule

bind enc_status_axil enc_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cw_pulse(cw_pulse), .ccw_pulse(ccw_pulse),
  .sw_level(sw_level), .s_arready(s_arready), .s_rdata(s_rdata),
  .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .rd_hit(rd_hit), .flag_vec(flag_vec)
);

// File: tb/sim_enc_status_axil.sv
module sim_enc_status_axil;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cw_pulse = 1'b0, ccw_pulse = 1'b0, sw_level = 1'b0;
  logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b0;
  logic s_arvalid = 1'b0, s_rready = 1'b0;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  enc_status_axil #(.AW(AW)) u0 (.*);

  // behavioural reference model
  bit [31:0] m_flags;
  bit        m_prev_sw;
  bit        m_rvalid;
  bit [31:0] m_rdata;
  bit        m_hit;
  bit        m_bvalid;
  bit        m_aw, m_w;

  always @(posedge clk) begin
    bit [31:0] ev, clr;
    bit rd_start, aw_take, w_take;
    if (!rst_n) begin
      m_flags = 0; m_prev_sw = 1; m_rvalid = 0; m_rdata = 0; m_hit = 0;
      m_bvalid = 0; m_aw = 0; m_w = 0;
    end else begin
      ev = 0;
      if (cw_pulse)  ev = ev + 32'h20;
      if (ccw_pulse) ev = ev + 32'h10;
      if (sw_level && !m_prev_sw) ev = ev + 32'h1;
      m_prev_sw = sw_level;
      clr = 0;
      rd_start = s_arvalid && !m_rvalid;
      if (m_rvalid && s_rready) begin
        if (m_hit) clr = m_rdata;
        m_rvalid = 0;
      end
      if (rd_start) begin
        m_hit   = (s_araddr / 4) == 0;
        m_rdata = m_hit ? m_flags : 0;
        m_rvalid = 1;
      end
      for (int b = 0; b < 32; b++)
        if (clr[b]) m_flags[b] = 0;
      m_flags = m_flags | ev;
      aw_take = s_awvalid && !m_bvalid && !m_aw;
      w_take  = s_wvalid  && !m_bvalid && !m_w;
      if (m_bvalid && s_bready && !((m_aw || aw_take) && (m_w || w_take))) m_bvalid = 0;
      if ((m_aw || aw_take) && (m_w || w_take)) begin
        m_bvalid = 1; m_aw = 0; m_w = 0;
      end else begin
        m_aw = m_aw || aw_take; m_w = m_w || w_take;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 arready", {31'b0, s_arready}, {31'b0, !m_rvalid});
      check("R7 rvalid", {31'b0, s_rvalid}, {31'b0, m_rvalid});
      if (m_rvalid) check("R4 rdata", s_rdata, m_rdata);
      check("R8 bvalid", {31'b0, s_bvalid}, {31'b0, m_bvalid});
      check("R8 awready", {31'b0, s_awready}, {31'b0, !m_bvalid && !m_aw});
    end
  end

  // read with optional stall and events at the address and data handshakes
  task automatic do_read(input logic [AW-1:0] addr, input int stall,
                         input logic [1:0] ev_ar, input logic [1:0] ev_r,
                         input logic [31:0] exp, input string tag);
    @(negedge clk);
    while (!s_arready) @(negedge clk);
    s_araddr = addr; s_arvalid = 1'b1;
    cw_pulse = ev_ar[1]; ccw_pulse = ev_ar[0];
    @(negedge clk);
    s_arvalid = 1'b0; cw_pulse = 1'b0; ccw_pulse = 1'b0;
    for (int k = 0; k < stall; k++) @(negedge clk);
    check(tag, s_rdata, exp);
    check({tag, " rresp R7"}, {30'b0, s_rresp}, 32'h0);
    s_rready = 1'b1; cw_pulse = ev_r[1]; ccw_pulse = ev_r[0];
    @(negedge clk);
    s_rready = 1'b0; cw_pulse = 1'b0; ccw_pulse = 1'b0;
  endtask

  task automatic pulse(input logic cw, input logic ccw);
    @(negedge clk);
    cw_pulse = cw; ccw_pulse = ccw;
    @(negedge clk);
    cw_pulse = 1'b0; ccw_pulse = 1'b0;
  endtask

  task automatic do_write(input bit data_first);
    @(negedge clk);
    s_wdata = 32'hFFFF_FFFF; s_wstrb = 4'hF; s_awaddr = '0;
    if (data_first) s_wvalid = 1'b1; else s_awvalid = 1'b1;
    @(negedge clk);
    s_wvalid = 1'b0; s_awvalid = 1'b0;
    @(negedge clk);
    if (data_first) s_awvalid = 1'b1; else s_wvalid = 1'b1;
    @(negedge clk);
    s_wvalid = 1'b0; s_awvalid = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 bvalid held", {31'b0, s_bvalid}, 32'h1);
    check("R8 bresp", {30'b0, s_bresp}, 32'h0);
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 arready", {31'b0, s_arready}, 32'h1);
    check("R9 awready", {31'b0, s_awready}, 32'h1);
    check("R9 wready", {31'b0, s_wready}, 32'h1);
    check("R9 rvalid", {31'b0, s_rvalid}, 32'h0);
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h0, "R9 empty");
    // R1 R2 clockwise then counter-clockwise
    pulse(1, 0);
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h20, "R2 cw");
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h0, "R4 cleared");
    pulse(0, 1);
    repeat (5) @(negedge clk);
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h10, "R2 ccw");
    // R3 switch edges
    sw_level = 1'b1;
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h1, "R3 press");
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h0, "R3 held");
    sw_level = 1'b0;
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h0, "R3 release");
    sw_level = 1'b1;
    pulse(1, 1);
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h31, "R1 all");
    sw_level = 1'b0;
    // R6 nonzero offset
    pulse(1, 0);
    do_read(4'h4, 0, 2'b00, 2'b00, 32'h0, "R6 miss");
    do_read(4'h8, 0, 2'b00, 2'b00, 32'h0, "R6 miss2");
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h20, "R6 kept");
    // R5 events at address acceptance and at the data handshake
    do_read(4'h0, 0, 2'b10, 2'b00, 32'h0, "R5 ar cycle");
    do_read(4'h0, 0, 2'b00, 2'b10, 32'h20, "R5 ar event");
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h20, "R5 r event");
    // R7 stall with events arriving while waiting
    pulse(0, 1);
    do_read(4'h0, 4, 2'b10, 2'b00, 32'h10, "R7 stall");
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h20, "R7 late event");
    // R8 writes in both orders leave flags alone
    pulse(1, 1);
    do_write(1'b1);
    do_write(1'b0);
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h30, "R8 unchanged");
    // R3 switch held through reset
    @(negedge clk);
    sw_level = 1'b1; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_read(4'h0, 0, 2'b00, 2'b00, 32'h0, "R3 reset held");
    sw_level = 1'b0;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule